// File: doc/BRIEF.md
# Three-Channel Match and Wrap Timer

This block is a memory-mapped timer peripheral with three independent counters of `DATA_W` bits. Each channel owns a count register that software can overwrite, a reload register and two compare registers. A shared control register switches each channel on, picks its tick source and gates its wrap interrupt. A shared status register and mask register cover all three channels, and they drive one level-sensitive interrupt line.

On each tick a channel steps one count up or down. When it passes its end value it takes the reload value and records a wrap. When the value it steps to equals either compare register, it records a match. The tick source is either every clock cycle or only the cycles in which the synchronous `ext_tick` qualifier is high. A build parameter selects a second control-bit layout. In that layout the bits are spaced differently, there are no direction bits, and every channel counts down.

Software reaches the block over a simple synchronous register bus. A write lands on the next rising clock edge. Read data is combinational from the address.

Top module: `tri_timer`

## Requirements
- R1: After reset every register reads 0 and `irq` is low.
- R2: Byte offsets decode on `addr[5:2]`. Channel c (c = 0, 1, 2) has its count at 0x10*c, reload at 0x10*c+4, compare A at 0x10*c+8 and compare B at 0x10*c+0xC. Control is at 0x30, status at 0x34 and mask at 0x38. Every register reads back what was written to it. Any other offset reads 0.
- R3: In the default layout, control bits 3c, 3c+1 and 3c+2 are the run, external-tick select and wrap-interrupt enable of channel c. Bit 9+c set to 1 makes channel c count up, and 0 makes it count down. Control reads back bits 11:0 only.
- R4: With `ALT_LAYOUT`=1, the run, select and enable bits of channel c sit at 4c, 4c+1 and 4c+2. Bits 3, 7 and 11 read 0, and every channel counts down.
- R5: When counting up, each tick adds 1. A tick at the all-ones value loads the reload value instead and sets the channel's wrap flag.
- R6: When counting down, each tick subtracts 1. A tick at 0 loads the reload value and sets the wrap flag, so a free run lasts reload+1 ticks.
- R7: A tick whose new count equals compare A sets status bit 3c, and one that equals compare B sets bit 3c+1. The wrap flag is bit 3c+2. This holds in both directions.
- R8: A channel whose run bit is 0 holds its count. With the select bit at 0 a running channel ticks every clock, and with it at 1 it ticks only in cycles where `ext_tick` is 1.
- R9: A count write takes effect on the next edge and replaces any tick in that cycle. It sets no status flag, even when the written value equals a compare register.
- R10: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R11: `irq` is the OR of all status bits whose mask bit is 1. A wrap bit also needs its channel's wrap-interrupt enable to be 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_tick | input | 1 | External tick qualifier, synchronous to clk |
| addr | input | 6 | Byte address of the register |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr |
| irq | output | 1 | Interrupt request, level |

## Verification
A register write, a count step, a flag set and a status clear all land on the one rising edge after the cycle in which they are presented. `irq` and `rdata` follow that edge within the same cycle, because they are combinational. The bench drives on the falling edge and samples 1 ns later, so every sample sees the state after a known number of edges. The tick-count tests rely on one rule: a timer that is switched on by one write and off by a later write gets two more ticks than the number of idle cycles between the two writes. This is because the edge that stores the stop value still ticks. The expected count and flags of every sequence are derived from that rule.

// File: rtl/tri_tmr_pkg.sv
// Shared constants and helpers for the three-channel timer.
// Assumes a fixed set of three channels, since the register map places
// the shared registers directly after the third channel.
package tri_tmr_pkg;
    localparam int N_CHAN = 3;
    localparam int CTRL_W = 12;
    localparam int ST_W   = 3 * N_CHAN;

    // word indices (byte offset / 4) of the shared registers
    localparam int IDX_CTRL = 12;
    localparam int IDX_STAT = 13;
    localparam int IDX_MASK = 14;

    // per-channel decoded configuration
    typedef struct packed {
        logic run;
        logic ext_sel;
        logic wrap_ie;
        logic up;
    } chan_cfg_t;

    // writable control bits for the selected layout
    function automatic logic [CTRL_W-1:0] ctrl_wmask(input bit alt);
        return alt ? 12'h777 : 12'hFFF;
    endfunction
endpackage

// File: rtl/tmr_cfg_map.sv
// Splits the shared control word into per-channel settings.
// The ALT parameter picks between the two bit layouts. The alternate
// layout has no direction bits, so its channels always count down.
module tmr_cfg_map
    import tri_tmr_pkg::*;
#(
    parameter bit ALT = 1'b0
) (
    input  logic [CTRL_W-1:0]           ctrl,
    output chan_cfg_t [N_CHAN-1:0]      cfg
);
    localparam int STRIDE = ALT ? 4 : 3;
    localparam int DIR_BASE = 9;

    for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
        // pick the three per-channel bits at this layout's stride
        assign cfg[c].run     = ctrl[STRIDE*c];
        assign cfg[c].ext_sel = ctrl[STRIDE*c+1];
        assign cfg[c].wrap_ie = ctrl[STRIDE*c+2];
        if (ALT) begin : g_down_only
            assign cfg[c].up = 1'b0;
        end else begin : g_dir
            assign cfg[c].up = ctrl[DIR_BASE+c];
        end
    end
endmodule

// File: rtl/tmr_chan.sv
// One counter channel. On each tick it steps up or down, reloads at the
// end of its range and reports match and wrap events for that edge.
// A software count write has priority over a tick in the same cycle
// and raises no event.
module tmr_chan #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         up,
    input  logic         cnt_wr,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] reload,
    input  logic [W-1:0] cmp_a,
    input  logic [W-1:0] cmp_b,
    output logic [W-1:0] count,
    output logic         ev_a,
    output logic         ev_b,
    output logic         ev_wrap
);
    logic [W-1:0] nxt;
    logic         at_end;

    // next value of the counter if a tick occurs
    always_comb begin
        at_end = up ? (count == {W{1'b1}}) : (count == '0);
        if (at_end)  nxt = reload;
        else if (up) nxt = count + 1'b1;
        else         nxt = count - 1'b1;
    end

    // events belong only to real ticks that no write overrides
    assign ev_wrap = tick & ~cnt_wr & at_end;
    assign ev_a    = tick & ~cnt_wr & (nxt == cmp_a);
    assign ev_b    = tick & ~cnt_wr & (nxt == cmp_b);

    // counter register: a write first, then a tick, otherwise hold
    always_ff @(posedge clk) begin
        if (!rst_n)      count <= '0;
        else if (cnt_wr) count <= wdata;
        else if (tick)   count <= nxt;
    end
endmodule

// File: rtl/tmr_status.sv
// Sticky event flags with write-one-to-clear and the interrupt reduction.
// Assumes a set and a clear of the same bit in one cycle resolve to set.
module tmr_status #(
    parameter int NB = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] set_v,
    input  logic          clr_en,
    input  logic [NB-1:0] clr_v,
    input  logic [NB-1:0] mask,
    input  logic [NB-1:0] gate,
    output logic [NB-1:0] status,
    output logic          irq
);
    logic [NB-1:0] clr_eff;

    // clear pattern applies only when the status register is written
    assign clr_eff = clr_en ? clr_v : '0;

    // sticky flag storage
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr_eff) | set_v;
    end

    // interrupt: any unmasked and ungated flag
    assign irq = |(status & mask & gate);
endmodule

// File: rtl/tri_timer.sv
// Three-channel timer with register bus. It holds the reload and compare
// registers, control and mask, decodes the bus and muxes read data.
// Assumes DATA_W >= 12 and ext_tick synchronous to clk.
module tri_timer
    import tri_tmr_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 6,
    parameter bit ALT_LAYOUT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_tick,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    localparam int IDX_W = ADDR_W - 2;
    localparam logic [CTRL_W-1:0] WMASK = ctrl_wmask(ALT_LAYOUT);

    logic [IDX_W-1:0]                idx;
    logic [CTRL_W-1:0]               ctrl_q;
    logic [ST_W-1:0]                 mask_q;
    logic [ST_W-1:0]                 status_q;
    logic [N_CHAN-1:0][DATA_W-1:0]   cnt_q, reload_q, cmpa_q, cmpb_q;
    logic [N_CHAN-1:0]               cnt_wr, tick_v, run_v, up_v;
    logic [ST_W-1:0]                 set_v, gate_v;
    chan_cfg_t [N_CHAN-1:0]          cfg;

    assign idx = addr[ADDR_W-1:2];

    tmr_cfg_map #(.ALT(ALT_LAYOUT)) u_map (
        .ctrl (ctrl_q),
        .cfg  (cfg)
    );

    // shared control and mask registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            mask_q <= '0;
        end else if (wr_en) begin
            if (idx == IDX_W'(IDX_CTRL)) ctrl_q <= wdata[CTRL_W-1:0] & WMASK;
            if (idx == IDX_W'(IDX_MASK)) mask_q <= wdata[ST_W-1:0];
        end
    end

    for (genvar c = 0; c < N_CHAN; c++) begin : g_ch
        assign cnt_wr[c] = wr_en && (idx == IDX_W'(4*c));
        assign run_v[c]  = cfg[c].run;
        assign up_v[c]   = cfg[c].up;
        assign tick_v[c] = cfg[c].run & (cfg[c].ext_sel ? ext_tick : 1'b1);
        assign gate_v[3*c]   = 1'b1;
        assign gate_v[3*c+1] = 1'b1;
        assign gate_v[3*c+2] = cfg[c].wrap_ie;

        // per-channel reload and compare registers
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                reload_q[c] <= '0;
                cmpa_q[c]   <= '0;
                cmpb_q[c]   <= '0;
            end else if (wr_en) begin
                if (idx == IDX_W'(4*c+1)) reload_q[c] <= wdata;
                if (idx == IDX_W'(4*c+2)) cmpa_q[c]   <= wdata;
                if (idx == IDX_W'(4*c+3)) cmpb_q[c]   <= wdata;
            end
        end

        tmr_chan #(.W(DATA_W)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick_v[c]),
            .up      (cfg[c].up),
            .cnt_wr  (cnt_wr[c]),
            .wdata   (wdata),
            .reload  (reload_q[c]),
            .cmp_a   (cmpa_q[c]),
            .cmp_b   (cmpb_q[c]),
            .count   (cnt_q[c]),
            .ev_a    (set_v[3*c]),
            .ev_b    (set_v[3*c+1]),
            .ev_wrap (set_v[3*c+2])
        );
    end

    tmr_status #(.NB(ST_W)) u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_v  (set_v),
        .clr_en (wr_en && (idx == IDX_W'(IDX_STAT))),
        .clr_v  (wdata[ST_W-1:0]),
        .mask   (mask_q),
        .gate   (gate_v),
        .status (status_q),
        .irq    (irq)
    );

    // read data mux
    always_comb begin
        rdata = '0;
        for (int c = 0; c < N_CHAN; c++) begin
            if (idx == IDX_W'(4*c))   rdata = cnt_q[c];
            if (idx == IDX_W'(4*c+1)) rdata = reload_q[c];
            if (idx == IDX_W'(4*c+2)) rdata = cmpa_q[c];
            if (idx == IDX_W'(4*c+3)) rdata = cmpb_q[c];
        end
        if (idx == IDX_W'(IDX_CTRL)) rdata = DATA_W'(ctrl_q);
        if (idx == IDX_W'(IDX_STAT)) rdata = DATA_W'(status_q);
        if (idx == IDX_W'(IDX_MASK)) rdata = DATA_W'(mask_q);
    end
endmodule

// File: rtl/tri_timer_chk.sv
// Property checker for tri_timer, bound to every instance. It watches
// channel 0 stepping, count writes, flag stickiness and the interrupt.
module tri_timer_chk #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4,
    parameter int ST_W   = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [IDX_W-1:0]  idx,
    input logic [DATA_W-1:0] wdata,
    input logic              irq,
    input logic [ST_W-1:0]   status,
    input logic [ST_W-1:0]   mask,
    input logic [DATA_W-1:0] cnt0,
    input logic              run0,
    input logic              up0,
    input logic              tick0
);
    logic wr_cnt0, wr_stat;
    assign wr_cnt0 = wr_en && (idx == '0);
    assign wr_stat = wr_en && (idx == IDX_W'(13));

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & mask) == '0) |-> !irq);                                  // R11
    AST_COUNT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt0 |=> (cnt0 == $past(wdata)));                                // R9
    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!run0 && !wr_cnt0) |=> $stable(cnt0));                             // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stat |=> (($past(status) & ~status) == '0));                    // R10
    AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick0 && up0 && !wr_cnt0 && cnt0 != '1) |=> (cnt0 == $past(cnt0) + 1'b1)); // R5
    AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick0 && !up0 && !wr_cnt0 && cnt0 != '0) |=> (cnt0 == $past(cnt0) - 1'b1)); // R6
endmodule

bind tri_timer tri_timer_chk #(
    .DATA_W (DATA_W),
    .IDX_W  (ADDR_W - 2),
    .ST_W   (tri_tmr_pkg::ST_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .idx    (idx),
    .wdata  (wdata),
    .irq    (irq),
    .status (status_q),
    .mask   (mask_q),
    .cnt0   (cnt_q[0]),
    .run0   (run_v[0]),
    .up0    (up_v[0]),
    .tick0  (tick_v[0])
);

// File: tb/sim_tri_timer.sv
// Directed bench: one task per scenario, each checking its own results.
// u0 uses the default layout and u1 the alternate one; both share the bus.
module sim_tri_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_tick = 1'b0;
    logic [5:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata, rdata1;
    logic        irq, irq1;
    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    tri_timer #(.ALT_LAYOUT(1'b0)) u0 (.clk(clk), .rst_n(rst_n), .ext_tick(ext_tick),
        .addr(addr), .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .irq(irq));
    tri_timer #(.ALT_LAYOUT(1'b1)) u1 (.clk(clk), .rst_n(rst_n), .ext_tick(ext_tick),
        .addr(addr), .wr_en(wr_en), .wdata(wdata), .rdata(rdata1), .irq(irq1));

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; wr_en = 1'b0; ext_tick = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    // sample at the current falling edge, before the next rising edge
    task automatic rd(input logic [5:0] a, output logic [31:0] d, output logic [31:0] d1);
        addr = a; #1; d = rdata; d1 = rdata1;
    endtask

    task automatic t_reset();
        logic [31:0] v, v1;
        do_reset();
        for (int a = 0; a < 16; a++) begin
            rd(6'(a*4), v, v1);
            chk(a == 15 ? "R2 unmapped read" : "R1 reset value", v, 32'h0);
        end
        chk("R1 irq after reset", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_regmap();
        logic [31:0] v, v1;
        do_reset();
        for (int c = 0; c < 3; c++)
            for (int k = 0; k < 4; k++)
                wr(6'(16*c + 4*k), 32'hA000_0000 + 32'(16*c + k));
        wr(6'h38, 32'h1FF);
        for (int c = 0; c < 3; c++)
            for (int k = 0; k < 4; k++) begin
                rd(6'(16*c + 4*k), v, v1);
                chk("R2 register readback", v, 32'hA000_0000 + 32'(16*c + k));
            end
        rd(6'h38, v, v1); chk("R2 mask readback", v, 32'h1FF);
        wr(6'h30, 32'hFFFF_FFFF);
        rd(6'h30, v, v1);
        chk("R3 default control readback", v, 32'hFFF);
        chk("R4 alternate control readback", v1, 32'h777);
        wr(6'h30, 32'h0);
    endtask

    task automatic t_up_wrap();
        logic [31:0] v, v1;
        do_reset();
        wr(6'h00, 32'hFFFF_FFFE); wr(6'h04, 32'd5); wr(6'h08, 32'hFFFF_FFFF);
        wr(6'h30, 32'h201);          // run ch0, count up
        repeat (1) @(negedge clk);   // 3 ticks: FFFFFFFF, 5, 6
        wr(6'h30, 32'h0);
        rd(6'h00, v, v1); chk("R5 up count after wrap", v, 32'd6);
        rd(6'h34, v, v1); chk("R7 up match A and wrap flags", v, 32'h5);
    endtask

    task automatic t_down_wrap();
        logic [31:0] v, v1;
        do_reset();
        wr(6'h00, 32'd3); wr(6'h04, 32'd7); wr(6'h08, 32'h100); wr(6'h0C, 32'd1);
        wr(6'h30, 32'h001);          // run ch0, count down
        repeat (4) @(negedge clk);   // 6 ticks: 2,1,0,7,6,5
        wr(6'h30, 32'h0);
        rd(6'h00, v, v1); chk("R6 down count after reload", v, 32'd5);
        rd(6'h34, v, v1); chk("R7 down match B and wrap flags", v, 32'h6);
    endtask

    task automatic t_hold_ext();
        logic [31:0] v, v1;
        do_reset();
        wr(6'h00, 32'd40);
        repeat (5) @(negedge clk);
        rd(6'h00, v, v1); chk("R8 stopped channel holds", v, 32'd40);
        wr(6'h30, 32'h203);          // run, external tick, up
        for (int p = 0; p < 4; p++) begin
            @(negedge clk); ext_tick = 1'b1;
            @(negedge clk); ext_tick = 1'b0;
            repeat (2) @(negedge clk);
        end
        wr(6'h30, 32'h0);
        rd(6'h00, v, v1); chk("R8 external tick count", v, 32'd44);
    endtask

    task automatic t_count_write();
        logic [31:0] v, v1;
        do_reset();
        wr(6'h08, 32'd100);
        wr(6'h30, 32'h201);
        repeat (3) @(negedge clk);
        wr(6'h00, 32'd100);
        rd(6'h00, v, v1); chk("R9 write overrides tick", v, 32'd100);
        repeat (2) @(negedge clk);
        rd(6'h00, v, v1); chk("R9 counting resumes", v, 32'd102);
        wr(6'h30, 32'h0);
        rd(6'h34, v, v1); chk("R9 write raises no flag", v, 32'h0);
    endtask

    task automatic t_other_chans();
        logic [31:0] v, v1;
        do_reset();
        wr(6'h20, 32'hFFFF_FFFF);
        wr(6'h30, 32'h840);          // run ch2, up: ticks 0 then 1
        wr(6'h30, 32'h0);
        rd(6'h20, v, v1); chk("R5 channel 2 wrap to reload", v, 32'd1);
        rd(6'h34, v, v1); chk("R7 channel 2 flag positions", v, 32'h1C0);
        do_reset();
        wr(6'h10, 32'd5); wr(6'h18, 32'd3); wr(6'h1C, 32'h50);
        wr(6'h30, 32'h008);          // run ch1, down: ticks 4 then 3
        wr(6'h30, 32'h0);
        rd(6'h10, v, v1); chk("R6 channel 1 down", v, 32'd3);
        rd(6'h34, v, v1); chk("R7 channel 1 match A bit", v, 32'h8);
    endtask

    task automatic t_irq_clear();
        logic [31:0] v, v1;
        do_reset();
        wr(6'h00, 32'hFFFF_FFFF);
        wr(6'h30, 32'h200);          // up, stopped
        wr(6'h30, 32'h201);          // 2 ticks: 0 then 1
        wr(6'h30, 32'h200);
        rd(6'h34, v, v1); chk("R7 flags after wrap to zero", v, 32'h7);
        chk("R11 irq low with empty mask", {31'b0, irq}, 32'h0);
        wr(6'h38, 32'h4);
        chk("R11 wrap bit gated by enable", {31'b0, irq}, 32'h0);
        wr(6'h30, 32'h204);
        chk("R11 wrap bit with enable", {31'b0, irq}, 32'h1);
        wr(6'h30, 32'h200); wr(6'h38, 32'h1);
        chk("R11 match bit needs no enable", {31'b0, irq}, 32'h1);
        wr(6'h34, 32'h1);
        rd(6'h34, v, v1); chk("R10 write one clears bit", v, 32'h6);
        chk("R10 irq drops after clear", {31'b0, irq}, 32'h0);
        wr(6'h34, 32'h0);
        rd(6'h34, v, v1); chk("R10 write zero keeps bits", v, 32'h6);
    endtask

    task automatic t_alt_layout();
        logic [31:0] v, v1;
        do_reset();
        wr(6'h30, 32'h888);
        rd(6'h30, v, v1); chk("R4 unused bits read zero", v1, 32'h0);
        do_reset();
        wr(6'h10, 32'd4); wr(6'h14, 32'd2);
        wr(6'h30, 32'h010);          // alt: run ch1, always down
        repeat (3) @(negedge clk);   // 5 ticks: 3,2,1,0,2
        wr(6'h30, 32'h0);
        rd(6'h10, v, v1); chk("R4 alternate layout counts down", v1, 32'd2);
        rd(6'h34, v, v1); chk("R4 alternate flags at channel 1", v1, 32'h38);
    endtask

    initial begin
        #(20 * 100000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_regmap();
        t_up_wrap();
        t_down_wrap();
        t_hold_ext();
        t_count_write();
        t_other_chans();
        t_irq_clear();
        t_alt_layout();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule